// File: doc/BRIEF.md
# Arithmetic-Coder Low Register Update Stage

This stage keeps the 10-bit low register of a binary arithmetic encoder. For each coded bin it takes the renormalization shift that the range stage has already worked out, an MPS/LPS flag and the MPS sub-range. It updates low in one clock cycle. It also reports how many code bits the step has resolved and how many are still outstanding. No bit-serial loop is used: both counts come from small lookup tables. Each table is indexed by the shift and by the top bits of low.

The stage fills the slot between range renormalization and bit packing. Each accepted bin gives one registered result. That result holds the emitted-bit count and the accumulated outstanding count. It also holds the upper seven bits of low as seen before the shift, for the packer. The full low register is also brought out, so the next stage can follow the coder state.

Top module: `lowupd_top`

## Requirements
- R1: While `rst` is high (synchronous), low, the outstanding count, `out_valid`, `out_emit_cnt` and `out_low_top` all go to zero.
- R2: The pre-shift value P equals low on an MPS bin (`in_lps`=0). On an LPS bin (`in_lps`=1), P is (low + `in_rmps`) mod 1024.
- R3: For a shift s of 1..6, bits 8..0 of the new low are bits 8..0 of (P << s). Bit 9 of the new low is 1 only when the field F = P[9:9-s] (s+1 bits) is all ones. For s=0 the new low is P.
- R4: For s≥1, the step's pending increment is the number of consecutive ones in F counted upward from its least significant bit P[9-s]. It is 0 when F is all ones. `out_emit_cnt` is s minus that increment (for example s=3, F=0111 gives emit 0 and pending 3).
- R5: `out_pend_cnt` is an accumulator. On a shifted bin with emit count 0 it adds the increment and saturates at 31. On a shifted bin with emit count above 0 it takes the increment itself.
- R6: A bin with shift 0 reports an emit count of 0 and leaves the outstanding count unchanged.
- R7: `out_low_top` carries P[9:3] of the bin.
- R8: Results appear on the clock edge that accepts the bin, with `out_valid` high. In a cycle without `in_valid`, `out_valid` is low and low and the outstanding count keep their values.
- R9: Shift codes 7 are handled as shift 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bin is presented this cycle |
| in_lps | input | 1 | 1 = least probable symbol path (add sub-range) |
| in_rmps | input | 9 | MPS sub-range from the range stage |
| in_shift | input | 3 | Renormalization shift count |
| out_valid | output | 1 | Registered result valid |
| out_emit_cnt | output | 3 | Bits resolved by the step |
| out_pend_cnt | output | 5 | Accumulated outstanding bits |
| out_low_top | output | 7 | Pre-shift low bits 9..3 |
| out_low | output | 10 | Current low register |

## Verification
The hardest condition to reach is a particular bit pattern at the top of low just before a given shift. That pattern decides both table lookups and the kept or cleared MSB. From the ports, low can only be steered through earlier bins. The bench therefore issues LPS bins with shift 0, which add up to two sub-ranges, to place low at any chosen value. This walks every field value for every shift from 1 to 6. The same steering sets up repeated all-outstanding steps, which drive the accumulator into saturation.

// File: rtl/lowupd_pkg.sv
package lowupd_pkg;

    localparam int LOW_W     = 10;
    localparam int MAX_SHIFT = 6;
    localparam int SHIFT_W   = 3;
    localparam int CNT_W     = 3;
    localparam int BOS_W     = 5;
    localparam int TOP_W     = 7;
    localparam int RMPS_W    = 9;

    typedef struct packed {
        logic              lps;
        logic [RMPS_W-1:0] rmps;
        logic [SHIFT_W-1:0] shift;
    } bin_req_t;

    typedef struct packed {
        logic [CNT_W-1:0] emit;
        logic [CNT_W-1:0] pend;
    } info_t;

    // consecutive ones from the LSB of a len-bit field; all-ones maps to 0
    function automatic logic [CNT_W-1:0] run_of_ones(input int unsigned val,
                                                     input int unsigned len);
        int unsigned n;
        logic        stop;
        n    = 0;
        stop = 1'b0;
        if (val == ((32'd1 << len) - 32'd1)) begin
            return '0;
        end
        for (int unsigned b = 0; b < len; b++) begin
            if (!stop) begin
                if (((val >> b) & 32'd1) == 32'd0) stop = 1'b1;
                else n = n + 1;
            end
        end
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/lowupd_pre_add.sv
module lowupd_pre_add
    import lowupd_pkg::*;
#(
    parameter int LW = LOW_W,
    parameter int RW = RMPS_W
) (
    input  logic [LW-1:0] low,
    input  logic          lps,
    input  logic [RW-1:0] rmps,
    output logic [LW-1:0] pre
);
    logic [LW-1:0] sum;

    always_comb begin
        sum = low + LW'(rmps);
        pre = lps ? sum : low;
    end
endmodule

// File: rtl/lowupd_info_rom.sv
module lowupd_info_rom
    import lowupd_pkg::*;
#(
    parameter int LW = LOW_W,
    parameter int MS = MAX_SHIFT,
    parameter int SW = SHIFT_W
) (
    input  logic [LW-1:0] pre,
    input  logic [SW-1:0] shift,
    output info_t         info
);
    logic [CNT_W-1:0] pend_by_s [MS+1];

    assign pend_by_s[0] = '0;

    for (genvar s = 1; s <= MS; s++) begin : g_shift
        localparam int FW    = s + 1;
        localparam int DEPTH = 1 << FW;
        logic [CNT_W-1:0] rom [DEPTH];
        logic [FW-1:0]    field;

        for (genvar k = 0; k < DEPTH; k++) begin : g_entry
            assign rom[k] = run_of_ones(k, FW);
        end

        assign field        = pre[LW-1 -: FW];
        assign pend_by_s[s] = rom[field];
    end

    always_comb begin
        if (int'(shift) <= MS) info.pend = pend_by_s[shift];
        else                   info.pend = '0;
        info.emit = CNT_W'(shift) - info.pend;
    end
endmodule

// File: rtl/lowupd_shifter.sv
module lowupd_shifter
    import lowupd_pkg::*;
#(
    parameter int LW = LOW_W,
    parameter int MS = MAX_SHIFT,
    parameter int SW = SHIFT_W
) (
    input  logic [LW-1:0] pre,
    input  logic [SW-1:0] shift,
    output logic [LW-1:0] low_next
);
    logic [LW-1:0] by_s [MS+1];

    assign by_s[0] = pre;

    for (genvar s = 1; s <= MS; s++) begin : g_shift
        logic [LW-1:0] sh;
        logic          keep_msb;
        assign sh       = pre << s;
        assign keep_msb = &pre[LW-1 -: s+1];
        assign by_s[s]  = {keep_msb, sh[LW-2:0]};
    end

    always_comb begin
        if (int'(shift) <= MS) low_next = by_s[shift];
        else                   low_next = pre;
    end
endmodule

// File: rtl/lowupd_acc.sv
module lowupd_acc
    import lowupd_pkg::*;
#(
    parameter int BW = BOS_W,
    parameter int SW = SHIFT_W
) (
    input  logic [BW-1:0] acc_q,
    input  logic [SW-1:0] shift,
    input  info_t         info,
    output logic [BW-1:0] acc_d
);
    localparam int SUM_W = BW + 1;
    localparam logic [BW-1:0] SAT = '1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, acc_q} + SUM_W'(info.pend);
        if (shift == '0) begin
            acc_d = acc_q;
        end else if (info.emit == '0) begin
            acc_d = sum[BW] ? SAT : sum[BW-1:0];
        end else begin
            acc_d = BW'(info.pend);
        end
    end
endmodule

// File: rtl/lowupd_top.sv
module lowupd_top
    import lowupd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_lps,
    input  logic [RMPS_W-1:0]  in_rmps,
    input  logic [SHIFT_W-1:0] in_shift,
    output logic               out_valid,
    output logic [CNT_W-1:0]   out_emit_cnt,
    output logic [BOS_W-1:0]   out_pend_cnt,
    output logic [TOP_W-1:0]   out_low_top,
    output logic [LOW_W-1:0]   out_low
);
    bin_req_t           req;
    logic [LOW_W-1:0]   low_q;
    logic [LOW_W-1:0]   pre;
    logic [LOW_W-1:0]   low_next;
    logic [BOS_W-1:0]   acc_q;
    logic [BOS_W-1:0]   acc_d;
    info_t              info;
    logic               valid_q;
    logic [CNT_W-1:0]   emit_q;
    logic [TOP_W-1:0]   top_q;

    always_comb begin
        req.lps   = in_lps;
        req.rmps  = in_rmps;
        req.shift = (in_shift > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : in_shift;
    end

    lowupd_pre_add u_pre_add (
        .low  (low_q),
        .lps  (req.lps),
        .rmps (req.rmps),
        .pre  (pre)
    );

    lowupd_info_rom u_info_rom (
        .pre   (pre),
        .shift (req.shift),
        .info  (info)
    );

    lowupd_shifter u_shifter (
        .pre      (pre),
        .shift    (req.shift),
        .low_next (low_next)
    );

    lowupd_acc u_acc (
        .acc_q (acc_q),
        .shift (req.shift),
        .info  (info),
        .acc_d (acc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            acc_q   <= '0;
            valid_q <= 1'b0;
            emit_q  <= '0;
            top_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                low_q  <= low_next;
                acc_q  <= acc_d;
                emit_q <= info.emit;
                top_q  <= pre[LOW_W-1 -: TOP_W];
            end
        end
    end

    assign out_valid    = valid_q;
    assign out_emit_cnt = emit_q;
    assign out_pend_cnt = acc_q;
    assign out_low_top  = top_q;
    assign out_low      = low_q;
endmodule

// File: rtl/lowupd_checker.sv
module lowupd_checker
    import lowupd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_lps,
    input logic [SHIFT_W-1:0] in_shift,
    input logic               out_valid,
    input logic [CNT_W-1:0]   out_emit_cnt,
    input logic [BOS_W-1:0]   out_pend_cnt,
    input logic [LOW_W-1:0]   out_low
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_low == '0 && out_pend_cnt == '0));

    p_mps_noshift_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_lps && in_shift == '0) |=> $stable(out_low));

    p_zero_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shift != '0) |=> (out_low[0] == 1'b0));

    p_emit_bound_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_emit_cnt) <= MAX_SHIFT));

    p_pend_grow_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shift != '0) |=>
            ((out_emit_cnt != '0) || (out_pend_cnt >= $past(out_pend_cnt))));

    p_zero_shift_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_shift == '0) |=> (out_emit_cnt == '0 && $stable(out_pend_cnt)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_low) && $stable(out_pend_cnt)));
endmodule

bind lowupd_top lowupd_checker u_lowupd_checker (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_lps       (in_lps),
    .in_shift     (in_shift),
    .out_valid    (out_valid),
    .out_emit_cnt (out_emit_cnt),
    .out_pend_cnt (out_pend_cnt),
    .out_low      (out_low)
);

// File: tb/lowupd_top_bench.sv
`timescale 1ns/1ps
module lowupd_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_lps = 1'b0;
    logic [8:0] in_rmps = '0;
    logic [2:0] in_shift = '0;
    logic       out_valid;
    logic [2:0] out_emit_cnt;
    logic [4:0] out_pend_cnt;
    logic [6:0] out_low_top;
    logic [9:0] out_low;

    int total = 0;
    int bad = 0;
    int m_low = 0;
    int m_acc = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lowupd_top u_lowupd_top (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_lps       (in_lps),
        .in_rmps      (in_rmps),
        .in_shift     (in_shift),
        .out_valid    (out_valid),
        .out_emit_cnt (out_emit_cnt),
        .out_pend_cnt (out_pend_cnt),
        .out_low_top  (out_low_top),
        .out_low      (out_low)
    );

    task automatic chk(input string req, input string ctx, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", req, ctx, act, exp);
        end
    endtask

    // one bin; starts and ends at a falling edge
    task automatic step(input bit lps, input int rmps, input int shift, input string ctx);
        int s, pre, field, len, pend, emit, nlow, top;
        s   = (shift > 6) ? 6 : shift;
        pre = lps ? ((m_low + rmps) % 1024) : m_low;
        top = pre / 8;
        pend = 0;
        emit = 0;
        nlow = pre;
        if (s > 0) begin
            len   = s + 1;
            field = pre / (1 << (9 - s));
            if (field != (1 << len) - 1) begin
                while (((field / (1 << pend)) % 2) == 1) pend++;
            end
            emit = s - pend;
            nlow = (pre * (1 << s)) % 512;
            if (field == (1 << len) - 1) nlow = nlow + 512;
            if (emit == 0) m_acc = (m_acc + pend > 31) ? 31 : m_acc + pend;
            else           m_acc = pend;
        end
        m_low    = nlow;
        in_lps   = lps;
        in_rmps  = 9'(rmps);
        in_shift = 3'(shift);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8", ctx, int'(out_valid), 1);
        chk("R4", ctx, int'(out_emit_cnt), emit);
        chk("R5", ctx, int'(out_pend_cnt), m_acc);
        chk("R7", ctx, int'(out_low_top), top);
        chk("R3", ctx, int'(out_low), m_low);
    endtask

    // steer low to a target with LPS bins of shift 0 (R2, R6)
    task automatic set_low(input int target);
        int d;
        d = (target - m_low + 1024) % 1024;
        if (d > 511) begin
            step(1'b1, 511, 0, "R2 steer");
            d = d - 511;
        end
        if (d > 0) step(1'b1, d, 0, "R6 steer");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hold_low, hold_acc;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid", int'(out_valid), 0);
        chk("R1", "reset low", int'(out_low), 0);
        chk("R1", "reset pend", int'(out_pend_cnt), 0);
        chk("R1", "reset emit", int'(out_emit_cnt), 0);
        chk("R1", "reset top", int'(out_low_top), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: MPS and LPS with shift 0
        step(1'b1, 300, 0, "R2 lps add");
        step(1'b0, 0, 0, "R2 mps hold");
        step(1'b1, 511, 0, "R2 lps wrap");

        // R8: idle cycle holds state
        hold_low = int'(out_low);
        hold_acc = int'(out_pend_cnt);
        @(negedge clk);
        chk("R8", "idle valid", int'(out_valid), 0);
        chk("R8", "idle low", int'(out_low), hold_low);
        chk("R8", "idle pend", int'(out_pend_cnt), hold_acc);

        // R4/R3: every field value for every shift
        for (int s = 1; s <= 6; s++) begin
            for (int f = 0; f < (1 << (s + 1)); f++) begin
                int fill;
                fill = (f * 37 + s) % (1 << (9 - s));
                set_low(f * (1 << (9 - s)) + fill);
                step(1'b0, 0, s, "R4 sweep");
            end
        end

        // R2: LPS bins combined with shifts
        for (int k = 0; k < 40; k++) begin
            step(1'b1, (k * 97 + 13) % 512, (k % 6) + 1, "R2 lps shift");
        end

        // R9: shift code 7 acts as 6
        for (int k = 0; k < 8; k++) begin
            set_low(k * 128 + 64);
            step(1'b0, 0, 7, "R9 clamp");
        end

        // R5: saturation at 31 with all-outstanding steps (F = 0111111)
        for (int k = 0; k < 7; k++) begin
            set_low(10'h1F8);
            step(1'b0, 0, 6, "R5 saturate");
        end
        chk("R5", "saturated value", int'(out_pend_cnt), 31);
        // R5: a resolving step replaces the accumulator
        set_low(10'h000);
        step(1'b0, 0, 2, "R5 replace");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule